// File: doc/BRIEF.md
# Flag-Synchronized Character Port

This block is the byte-wide character port of a small accumulator processor. It connects a keyboard-style source and a printer-style sink to the CPU. Two one-bit status flags absorb the large speed difference between the CPU and these devices. The input side holds one received byte until the CPU reads it. The output side holds one byte from the CPU until the sink reports that the byte has been printed.

The device edges are valid/ready. On the source side, a byte offered with `kbd_valid` while `kbd_ready` is high is taken in that cycle. A byte offered while `kbd_ready` is low gets no back-pressure: it is simply discarded, and a source that wants the byte delivered must keep offering it. There is one exception. If the CPU read that empties the register lands in the same cycle as the offer, the byte is parked and lands one cycle later.

On the sink side, `prt_valid` stays high for as long as a character is pending, and `prt_done` is the sink's one-cycle completion pulse. The CPU side uses plain strobes and two status flags. All strobes are synchronous to `clk`.

Top module: `chario_port`

## Requirements
- R1: After reset `in_flag` is 0 and `out_flag` is 1, so `kbd_ready` is 1 and `prt_valid` is 0.
- R2: An offer (`kbd_valid`=1) while `kbd_ready`=1 is captured on that clock edge. From the next cycle `cpu_rd_data` equals the offered byte, `in_flag` is 1 and `kbd_ready` is 0.
- R3: An offer while `in_flag`=1 with no CPU read in the same cycle is dropped. `cpu_rd_data` and `in_flag` are unchanged.
- R4: `cpu_rd` while `in_flag`=1 clears `in_flag` on the next cycle, and capture is enabled again. `cpu_rd` while `in_flag`=0 has no effect on `cpu_rd_data` or the flags.
- R5: If `cpu_rd` and an offer share a cycle while `in_flag`=1, then `in_flag` is 0 for exactly one cycle. After that cycle `in_flag` is 1 and `cpu_rd_data` holds the new byte.
- R6: An offer made during that one-cycle gap (when `in_flag`=0 and `kbd_ready`=0) is dropped, and the parked byte is kept.
- R7: `cpu_wr` while `out_flag`=1 loads `cpu_wr_data` into `prt_data`. From the next cycle `out_flag` is 0 and `prt_valid` is 1.
- R8: `cpu_wr` while `out_flag`=0 is ignored, and `prt_data` keeps the pending byte.
- R9: `prt_done` while `out_flag`=0 sets `out_flag` on the next cycle, and `prt_valid` drops. `prt_done` while `out_flag`=1 and no write is dropped.
- R10: If `cpu_wr` and `prt_done` share a cycle while `out_flag`=1, the write is accepted and `out_flag` is 0 for exactly one cycle. It then returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kbd_valid | input | 1 | Source offers a byte this cycle |
| kbd_data | input | 8 | Offered character code |
| kbd_ready | output | 1 | Input register free and no parked byte |
| cpu_rd | input | 1 | CPU takes the input byte and clears `in_flag` |
| cpu_rd_data | output | 8 | Input register contents toward the accumulator |
| in_flag | output | 1 | Input byte waiting for the CPU |
| cpu_wr | input | 1 | CPU write of an accumulator byte |
| cpu_wr_data | input | 8 | Byte to send |
| out_flag | output | 1 | Output register free for a new write |
| prt_valid | output | 1 | Character pending for the sink |
| prt_data | output | 8 | Pending character |
| prt_done | input | 1 | Sink finished printing (one-cycle pulse) |

## Verification
Each flag has two events that can coincide in one cycle: the CPU clearing it and the device setting it. On the input side this is a `cpu_rd` issued together with a fresh offer. On the output side it is a `cpu_wr` issued together with a `prt_done` pulse. The bench drives both strobes on the same falling edge. It then checks the flag on the next two cycles: it must be low first and high second. It also checks that the parked input byte, not the old one, appears on `cpu_rd_data`, and that a further offer made during the gap cycle is discarded.

// File: rtl/chario_pkg.sv
package chario_pkg;
  // Three-state flag: clear, set, or clear with a set already queued.
  typedef enum logic [1:0] {
    FLG_CLEAR = 2'b00,
    FLG_SET   = 2'b01,
    FLG_DEFER = 2'b10
  } flag_st_t;

  localparam int unsigned CHAR_W_DEF = 8;
endpackage

// File: rtl/chario_flag.sv
module chario_flag
  import chario_pkg::*;
#(
  parameter bit RST_SET = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic flag,
  output logic defer
);
  localparam flag_st_t RST_ST = RST_SET ? FLG_SET : FLG_CLEAR;

  flag_st_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      FLG_CLEAR: if (set_req) st_d = FLG_SET;
      // A clear always wins; a set in the same cycle is queued one cycle.
      FLG_SET:   if (clr_req) st_d = set_req ? FLG_DEFER : FLG_CLEAR;
      FLG_DEFER: st_d = FLG_SET;
      default:   st_d = RST_ST;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= RST_ST;
    else        st_q <= st_d;
  end

  assign flag  = (st_q == FLG_SET);
  assign defer = (st_q == FLG_DEFER);
endmodule

// File: rtl/chario_in_chan.sv
module chario_in_chan #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         kbd_valid,
  input  logic [W-1:0] kbd_data,
  output logic         kbd_ready,
  input  logic         cpu_rd,
  output logic [W-1:0] hold_q,
  output logic         in_flag
);
  logic         defer;
  logic [W-1:0] park_q;
  logic         take_now, take_park;

  chario_flag #(.RST_SET(1'b0)) u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_req (kbd_valid),
    .clr_req (cpu_rd),
    .flag    (in_flag),
    .defer   (defer)
  );

  assign kbd_ready = ~in_flag & ~defer;
  assign take_now  = kbd_valid & kbd_ready;
  assign take_park = kbd_valid & in_flag & cpu_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      park_q <= '0;
    end else begin
      if (take_park) park_q <= kbd_data;
      if (defer)         hold_q <= park_q;
      else if (take_now) hold_q <= kbd_data;
    end
  end
endmodule

// File: rtl/chario_out_chan.sv
module chario_out_chan #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cpu_wr,
  input  logic [W-1:0] cpu_wr_data,
  input  logic         prt_done,
  output logic         out_flag,
  output logic         prt_valid,
  output logic [W-1:0] prt_data
);
  logic defer;

  chario_flag #(.RST_SET(1'b1)) u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_req (prt_done),
    .clr_req (cpu_wr),
    .flag    (out_flag),
    .defer   (defer)
  );

  assign prt_valid = ~out_flag;

  always_ff @(posedge clk) begin
    if (!rst_n)                prt_data <= '0;
    else if (cpu_wr && out_flag) prt_data <= cpu_wr_data;
  end
endmodule

// File: rtl/chario_port.sv
module chario_port
  import chario_pkg::*;
#(
  parameter int unsigned CHAR_W = CHAR_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kbd_valid,
  input  logic [CHAR_W-1:0] kbd_data,
  output logic              kbd_ready,
  input  logic              cpu_rd,
  output logic [CHAR_W-1:0] cpu_rd_data,
  output logic              in_flag,
  input  logic              cpu_wr,
  input  logic [CHAR_W-1:0] cpu_wr_data,
  output logic              out_flag,
  output logic              prt_valid,
  output logic [CHAR_W-1:0] prt_data,
  input  logic              prt_done
);
  chario_in_chan #(.W(CHAR_W)) u_in (
    .clk       (clk),
    .rst_n     (rst_n),
    .kbd_valid (kbd_valid),
    .kbd_data  (kbd_data),
    .kbd_ready (kbd_ready),
    .cpu_rd    (cpu_rd),
    .hold_q    (cpu_rd_data),
    .in_flag   (in_flag)
  );

  chario_out_chan #(.W(CHAR_W)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_wr      (cpu_wr),
    .cpu_wr_data (cpu_wr_data),
    .prt_done    (prt_done),
    .out_flag    (out_flag),
    .prt_valid   (prt_valid),
    .prt_data    (prt_data)
  );
endmodule

// File: rtl/chario_port_chk.sv
module chario_port_chk #(
  parameter int unsigned CHAR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              kbd_valid,
  input logic [CHAR_W-1:0] kbd_data,
  input logic              kbd_ready,
  input logic              cpu_rd,
  input logic [CHAR_W-1:0] cpu_rd_data,
  input logic              in_flag,
  input logic              cpu_wr,
  input logic [CHAR_W-1:0] cpu_wr_data,
  input logic              out_flag,
  input logic              prt_valid,
  input logic [CHAR_W-1:0] prt_data,
  input logic              prt_done
);
  // R2
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kbd_valid && kbd_ready |=> in_flag && !kbd_ready && cpu_rd_data == $past(kbd_data));
  // R3
  locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kbd_valid && in_flag && !cpu_rd |=> in_flag && $stable(cpu_rd_data));
  // R4
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd && in_flag |=> !in_flag);
  // R5
  rd_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd && in_flag && kbd_valid |=> !in_flag ##1 in_flag);
  // R7
  wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && out_flag |=> prt_valid && prt_data == $past(cpu_wr_data));
  // R8
  wr_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && !out_flag |=> $stable(prt_data));
  // R9
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prt_done && prt_valid |=> out_flag && !prt_valid);
  // R10
  wr_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && out_flag && prt_done |=> !out_flag ##1 out_flag);
endmodule

bind chario_port chario_port_chk #(.CHAR_W(CHAR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .kbd_valid   (kbd_valid),
  .kbd_data    (kbd_data),
  .kbd_ready   (kbd_ready),
  .cpu_rd      (cpu_rd),
  .cpu_rd_data (cpu_rd_data),
  .in_flag     (in_flag),
  .cpu_wr      (cpu_wr),
  .cpu_wr_data (cpu_wr_data),
  .out_flag    (out_flag),
  .prt_valid   (prt_valid),
  .prt_data    (prt_data),
  .prt_done    (prt_done)
);

// File: tb/chario_port_tb.sv
`timescale 1ns/1ps
module chario_port_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       kbd_valid, cpu_rd, cpu_wr, prt_done;
  logic [7:0] kbd_data, cpu_wr_data;
  logic       kbd_ready, in_flag, out_flag, prt_valid;
  logic [7:0] cpu_rd_data, prt_data;
  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  chario_port u_dut (
    .clk(clk), .rst_n(rst_n),
    .kbd_valid(kbd_valid), .kbd_data(kbd_data), .kbd_ready(kbd_ready),
    .cpu_rd(cpu_rd), .cpu_rd_data(cpu_rd_data), .in_flag(in_flag),
    .cpu_wr(cpu_wr), .cpu_wr_data(cpu_wr_data), .out_flag(out_flag),
    .prt_valid(prt_valid), .prt_data(prt_data), .prt_done(prt_done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Inputs change just after a falling edge; one rising edge; sample at the next falling edge.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    kbd_valid = 0; cpu_rd = 0; cpu_wr = 0; prt_done = 0;
  endtask

  task automatic t_reset();
    chk("R1 in_flag", in_flag, 0);
    chk("R1 out_flag", out_flag, 1);
    chk("R1 kbd_ready", kbd_ready, 1);
    chk("R1 prt_valid", prt_valid, 0);
  endtask

  task automatic t_capture();
    kbd_valid = 1; kbd_data = 8'h41; step();
    chk("R2 in_flag", in_flag, 1);
    chk("R2 data", cpu_rd_data, 8'h41);
    chk("R2 kbd_ready", kbd_ready, 0);
  endtask

  task automatic t_locked();
    kbd_valid = 1; kbd_data = 8'h5A; step();
    chk("R3 data kept", cpu_rd_data, 8'h41);
    chk("R3 in_flag", in_flag, 1);
  endtask

  task automatic t_read();
    cpu_rd = 1; step();
    chk("R4 in_flag cleared", in_flag, 0);
    chk("R4 kbd_ready", kbd_ready, 1);
    cpu_rd = 1; step();
    chk("R4 idle read flag", in_flag, 0);
    chk("R4 idle read data", cpu_rd_data, 8'h41);
    kbd_valid = 1; kbd_data = 8'h33; step();
    chk("R4 recapture", cpu_rd_data, 8'h33);
  endtask

  task automatic t_rd_collide();
    cpu_rd = 1; kbd_valid = 1; kbd_data = 8'h77; step();
    chk("R5 gap flag", in_flag, 0);
    chk("R5 gap ready", kbd_ready, 0);
    kbd_valid = 1; kbd_data = 8'h99; step();
    chk("R5 flag back", in_flag, 1);
    chk("R5 parked byte", cpu_rd_data, 8'h77);
    step();
    chk("R6 gap offer dropped", cpu_rd_data, 8'h77);
    chk("R6 flag held", in_flag, 1);
    cpu_rd = 1; step();
  endtask

  task automatic t_write();
    cpu_wr = 1; cpu_wr_data = 8'hC3; step();
    chk("R7 out_flag", out_flag, 0);
    chk("R7 prt_valid", prt_valid, 1);
    chk("R7 prt_data", prt_data, 8'hC3);
  endtask

  task automatic t_write_busy();
    cpu_wr = 1; cpu_wr_data = 8'h11; step();
    chk("R8 data kept", prt_data, 8'hC3);
    chk("R8 flag", out_flag, 0);
  endtask

  task automatic t_done();
    prt_done = 1; step();
    chk("R9 out_flag set", out_flag, 1);
    chk("R9 prt_valid", prt_valid, 0);
    prt_done = 1; step();
    chk("R9 stray done", out_flag, 1);
    cpu_wr = 1; cpu_wr_data = 8'h6E; step();
    chk("R9 write after done", prt_data, 8'h6E);
    prt_done = 1; step();
  endtask

  task automatic t_wr_collide();
    cpu_wr = 1; cpu_wr_data = 8'hA5; prt_done = 1; step();
    chk("R10 gap flag", out_flag, 0);
    chk("R10 data", prt_data, 8'hA5);
    step();
    chk("R10 flag back", out_flag, 1);
  endtask

  initial begin
    #4_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; kbd_valid = 0; cpu_rd = 0; cpu_wr = 0; prt_done = 0;
    kbd_data = 0; cpu_wr_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_capture();
    t_locked();
    t_read();
    t_rd_collide();
    t_write();
    t_write_busy();
    t_done();
    t_wr_collide();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule